// File: doc/BRIEF.md
# Multi-Push Single-Pop FIFO

A bounded first-in first-out store whose write side accepts a whole group of values in one cycle, while its read side releases at most one value per cycle. In each cycle a producer presents up to `LANES` data words on parallel lanes, together with a count of how many of those lanes hold real data. The used lanes are appended in lane order. The consumer sees one data word and a valid flag. When the flag is low, no value is present in that cycle.

The output is taken from registered state. A value stored at the end of one cycle can appear at the output no earlier than the next cycle. The read side has no stall. Whenever the store holds an entry at the start of a cycle, that entry is shown and removed. If a group does not fit in the free space, the part that fits is kept in lane order and the rest is dropped. A sticky overflow flag records the loss. The block also reports its occupancy and a full indication.

Top module: `multi_push_fifo`

## Requirements
- R1: A synchronous active-high reset empties the store: occupancy 0, `outValid` low, `overflow` low and `full` low in the cycle after the reset edge.
- R2: With `inCount` = n (0..LANES), lanes 0..n-1 are appended. Lane i occupies bits [i*DATA_W +: DATA_W] of `inData`, and lane 0 is the oldest value of the group.
- R3: Values leave in strict arrival order across cycles. Within one group, lower lane indices leave first.
- R4: A value accepted in cycle t is first visible on the output in cycle t+1 and never in cycle t.
- R5: In every cycle whose starting occupancy is nonzero, `outValid` is high and `outData` shows the oldest entry. That entry is removed at the end of the cycle, and at most one entry leaves per cycle.
- R6: When the starting occupancy is zero, `outValid` is low and `outData` is all zeros.
- R7: The free space in a cycle is DEPTH minus occupancy, plus one if an entry is popped in that cycle. If the group is larger than the free space, only its lowest-indexed lanes up to the free space are stored, the rest are dropped, and `overflow` goes high in the next cycle.
- R8: Once set, `overflow` stays high until reset.
- R9: The next occupancy equals the current occupancy, minus the pop, plus the accepted count. It never exceeds DEPTH, and `full` is high exactly when occupancy equals DEPTH.
- R10: An `inCount` value above LANES is treated as LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | LANES*DATA_W | Packed input lanes, lane 0 in the low bits |
| inCount | input | $clog2(LANES+1) | Number of valid lanes this cycle |
| outData | output | DATA_W | Oldest entry, zero when absent |
| outValid | output | 1 | High when outData carries a value |
| occupancy | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow | output | 1 | Sticky flag for dropped input values |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
The bench targets a group that only partly fits, with and without a pop in the same cycle. A design that ignores the freed slot drops one value too many, and a design that keeps the wrong lanes delivers values out of order. It drives pointer wrap-around with groups that straddle the end of storage, where a bad modulo step overwrites live data. It also drives an out-of-range lane count, which an unclamped design would treat as more than LANES pushes. Finally, it checks that a value pushed into an empty store does not reach the output in the same cycle, and that a reset clears a set overflow flag. A design that bypasses the store would show the value a cycle early, and one with a flag that never clears would keep reporting overflow after reset.

// File: rtl/mpfifo_pkg.sv
package mpfifo_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic doPop;   // head leaves at end of cycle
    logic doPush;  // at least one lane is accepted
  } fifoStrobes_t;
endpackage

// File: rtl/mpfifo_ctrl.sv
module mpfifo_ctrl
  import mpfifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] inCount,
  output fifoStrobes_t     strobes,
  output logic [CNT_W-1:0] acceptCnt,
  output logic [OCC_W-1:0] occupancy,
  output logic             overflow,
  output logic             full,
  output logic             outValid
);
  localparam int OW = OCC_W + 1;

  logic [OW-1:0] effW, freeW, accW, occW;
  logic          popNow, dropNow;

  always_comb begin
    popNow  = (occupancy != '0);
    occW    = OW'(occupancy);
    effW    = (inCount > CNT_W'(LANES)) ? OW'(LANES) : OW'(inCount);
    freeW   = OW'(DEPTH) - occW + OW'(popNow);
    accW    = (effW <= freeW) ? effW : freeW;
    dropNow = (accW < effW);
  end

  assign acceptCnt      = CNT_W'(accW);
  assign strobes.doPop  = popNow;
  assign strobes.doPush = (accW != '0);
  assign outValid       = popNow;
  assign full           = (occupancy == OCC_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      occupancy <= '0;
      overflow  <= 1'b0;
    end else begin
      occupancy <= OCC_W'(occW - OW'(popNow) + accW);
      if (dropNow) overflow <= 1'b1;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occupancy <= OCC_W'(DEPTH)) else $error("occupancy above depth"); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow) else $error("overflow cleared"); // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    dropNow |=> overflow) else $error("drop without flag"); // R7
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (occupancy == '0 && !overflow && !outValid)) else $error("reset state"); // R1
  AST_EMPTY_GAIN: assert property (@(posedge clk) disable iff (rst)
    !outValid |=> occupancy <= OCC_W'(LANES)) else $error("gain above lanes"); // R10
endmodule

// File: rtl/mpfifo_datapath.sv
module mpfifo_datapath
  import mpfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fifoStrobes_t            strobes,
  input  logic [CNT_W-1:0]        acceptCnt,
  input  logic [LANES*DATA_W-1:0] inData,
  output logic [DATA_W-1:0]       outData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] laneVal [LANES];
  logic [PTR_W-1:0]  slotIdx [LANES];
  logic [PTR_W-1:0]  wrNext, rdNext;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] base,
                                               input logic [PTR_W:0] step);
    logic [PTR_W:0] sum;
    sum = {1'b0, base} + step;
    if (sum >= (PTR_W+1)'(DEPTH)) sum = sum - (PTR_W+1)'(DEPTH);
    return sum[PTR_W-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneVal[g] = inData[g*DATA_W +: DATA_W];
    assign slotIdx[g] = wrapAdd(wrPtr, (PTR_W+1)'(g));
  end

  assign wrNext  = wrapAdd(wrPtr, (PTR_W+1)'(acceptCnt));
  assign rdNext  = wrapAdd(rdPtr, (PTR_W+1)'(1));
  assign outData = strobes.doPop ? mem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.doPop)  rdPtr <= rdNext;
      if (strobes.doPush) wrPtr <= wrNext;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!rst && (CNT_W'(i) < acceptCnt)) mem[slotIdx[i]] <= laneVal[i];
    end
  end

  AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
    strobes.doPush |-> (acceptCnt != '0 && acceptCnt <= CNT_W'(LANES))) else $error("push count"); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    strobes.doPop |=> (rdPtr != $past(rdPtr) || DEPTH == 1)) else $error("pop did not advance"); // R5
endmodule

// File: rtl/multi_push_fifo.sv
module multi_push_fifo
  import mpfifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]        inCount,
  output logic [DATA_W-1:0]       outData,
  output logic                    outValid,
  output logic [OCC_W-1:0]        occupancy,
  output logic                    overflow,
  output logic                    full
);
  fifoStrobes_t     strobes;
  logic [CNT_W-1:0] acceptCnt;

  mpfifo_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst(rst), .inCount(inCount), .strobes(strobes),
    .acceptCnt(acceptCnt), .occupancy(occupancy), .overflow(overflow),
    .full(full), .outValid(outValid)
  );

  mpfifo_datapath #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .acceptCnt(acceptCnt),
    .inData(inData), .outData(outData)
  );
endmodule

// File: tb/multi_push_fifo_tb.sv
module multi_push_fifo_tb;
  localparam int DW = 8, L = 4, D = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [L*DW-1:0] inData = '0;
  logic [2:0]    inCount = '0;
  logic [DW-1:0] outData;
  logic          outValid, overflow, full;
  logic [3:0]    occupancy;

  int checks = 0, failures = 0;
  int q[$];
  bit mOvf = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  multi_push_fifo #(.DATA_W(DW), .LANES(L), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .inData(inData), .inCount(inCount),
    .outData(outData), .outValid(outValid), .occupancy(occupancy),
    .overflow(overflow), .full(full)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    int sz = q.size();
    chk(outValid == (sz > 0), {tag, " R5 valid"}, outValid, sz > 0);
    if (sz > 0) chk(outData == q[0][DW-1:0], {tag, " R3 order"}, outData, q[0]);
    else        chk(outData == '0, {tag, " R6 absent data"}, outData, 0);
    chk(occupancy == sz, {tag, " R9 occupancy"}, occupancy, sz);
    chk(full == (sz == D), {tag, " R9 full"}, full, sz == D);
    chk(overflow == mOvf, {tag, " R7 R8 overflow"}, overflow, mOvf);
  endtask

  // drive one cycle from the negedge, update model, check at next negedge
  task automatic step(input int n, input logic [L*DW-1:0] d, input string tag);
    int eff, free, acc;
    inCount = 3'(n);
    inData  = d;
    if (q.size() > 0) void'(q.pop_front());
    eff  = (n > L) ? L : n;
    free = D - q.size();
    acc  = (eff < free) ? eff : free;
    for (int i = 0; i < acc; i++) q.push_back(int'(d[i*DW +: DW]));
    if (eff > acc) mOvf = 1;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset;
    rst = 1'b1; inCount = '0;
    @(negedge clk);
    q.delete(); mOvf = 0;
    chk(!outValid && occupancy == 0 && !overflow && !full, "R1 reset state",
        {outValid, overflow, full}, 0);
    rst = 1'b0;
  endtask

  function automatic logic [L*DW-1:0] pack4(input int a, input int b, input int c, input int e);
    return {8'(e), 8'(c), 8'(b), 8'(a)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();

    // R4: value pushed into empty store is not visible in the same cycle
    inCount = 3'd1; inData = pack4(8'hA5, 0, 0, 0);
    #1;
    chk(!outValid, "R4 same-cycle bypass", outValid, 0);
    step(1, pack4(8'hA5, 0, 0, 0), "R4 push one");
    step(0, '0, "R4 drained");

    // R2/R3: lane order within a group
    step(3, pack4(1, 2, 3, 99), "R2 group of three");
    step(0, '0, "R2 pop");
    step(0, '0, "R2 pop");
    step(0, '0, "R2 pop");

    // R7: fill, then partial group with same-cycle pop freeing one slot
    step(4, pack4(10, 11, 12, 13), "R7 fill a");
    step(4, pack4(14, 15, 16, 17), "R7 fill b");
    step(4, pack4(18, 19, 20, 21), "R7 partial");
    step(4, pack4(22, 23, 24, 25), "R7 full drop");
    // R8: sticky while draining
    for (int k = 0; k < 10; k++) step(0, '0, "R8 sticky drain");

    // R10: out-of-range count
    step(7, pack4(30, 31, 32, 33), "R10 count clamp");
    step(6, pack4(34, 35, 36, 37), "R10 count clamp b");

    // R1: reset clears overflow
    doReset();
    step(0, '0, "R1 after reset");

    // wrap-around with straddling groups, then random traffic
    for (int k = 0; k < 400; k++) begin
      int n = int'($urandom_range(0, 5));
      logic [L*DW-1:0] d = {$urandom, $urandom} >> 0;
      if (n == 5) n = 7;
      if (k == 200) doReset();
      step(n, d, "R3 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule